// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block watches a received byte stream and decides, at the end of each frame, whether the frame is kept or discarded. It takes the first six bytes of the frame as the destination address and compares them against four programmable station addresses and the all-ones broadcast address. It also checks the frame length against a fixed legal range and two optional oversize limits. The result is a keep/discard flag and a 32-bit word with one bit set that names the rule that matched.

Software programs the four address slots and a small configuration word through a simple write port. A slot is only used for matching while its valid flag is set. Writing the slot's upper 32 bits clears the flag, and writing its lower 16 bits sets it again. Software can therefore rewrite an address without a half-updated value ever matching. The verdict appears one clock after the last byte of a frame and is qualified by a single-cycle strobe.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset every slot is invalid and the configuration word is zero, so a frame addressed to 00:00:00:00:00:00 is discarded with code zero, and a broadcast frame is kept.
- R2: Writes use `regAddr`. Address 0 is the configuration word, with bit 0 = no-broadcast, bit 1 = keep-all, bit 2 = jumbo enable and bit 3 = big-frame enable. Slot k (k = 0..3) has its upper register at 2+2k and its lower register at 3+2k. Writing the upper register clears that slot's valid flag. Writing the lower register stores only data bits 15:0 and sets the flag.
- R3: The first received byte is destination byte 0. The upper register holds bytes 0..3 with byte 0 in bits 31:24, and the lower register holds byte 4 in bits 15:8 and byte 5 in bits 7:0. A valid slot matches only when all six bytes are equal.
- R4: Matches are tried in the order slot 0, slot 1, slot 2, slot 3, then broadcast, and only the first is reported. Slot k sets code bit 26-k, broadcast sets code bit 31, and zero means no match.
- R5: An all-ones destination matches broadcast only while the no-broadcast bit is clear.
- R6: A frame of legal length is kept when its code is non-zero, or when its code is zero and the keep-all bit is set. Otherwise it is discarded.
- R7: A frame shorter than 6 bytes or longer than 10240 bytes is always discarded, and its code is zero.
- R8: A frame longer than 1536 bytes is discarded unless jumbo is enabled. A frame longer than 1518 bytes is discarded unless big-frame is enabled. Both limits apply independently, and a length-rejected frame reports code zero.
- R9: `decValid` is high for exactly the one cycle after the clock edge that takes the end-of-frame byte. While it is low, `decAccept` and `decCode` are zero.
- R10: A byte counts only when `rxValid` is high, and only on the start-of-frame beat or inside a frame. An end-of-frame marker outside a frame gives no verdict. A new start-of-frame marker inside a frame restarts the address capture and the length count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register index |
| regWrData | input | 32 | Register write data |
| rxValid | input | 1 | Byte qualifier |
| rxData | input | 8 | Received byte |
| rxSof | input | 1 | First byte of frame |
| rxEof | input | 1 | Last byte of frame |
| decValid | output | 1 | Verdict strobe |
| decAccept | output | 1 | Frame kept |
| decCode | output | 32 | One-hot match code |

## Verification
The embedded properties check the following on every cycle: the strobe timing against the internal end-of-frame strobe, that the code is one-hot, that a non-zero code always means the frame is kept, that keeping an unmatched frame needs keep-all, that kept frames have legal lengths, and that each slot's valid flag follows register writes. The scenarios cover the rest. These are the exact priority between slots across all sixteen valid-flag patterns, the byte order of stored addresses, the broadcast and keep-all combinations, the length boundaries on either side of each limit under every oversize setting, and the framing corner cases of stray end markers and restarted frames.

// File: rtl/addr_filter_pkg.sv
package addr_filter_pkg;

  // Per-byte strobes from control to datapath
  typedef struct packed {
    logic byteEn;
    logic frameStart;
    logic frameEnd;
  } fltStrobe_t;

  // Configuration word, bit 0 is noBcast
  typedef struct packed {
    logic bigEn;
    logic jumboEn;
    logic copyAll;
    logic noBcast;
  } fltCfg_t;

  localparam int unsigned CFG_W = $bits(fltCfg_t);

endpackage

// File: rtl/addr_filter_ctrl.sv
module addr_filter_ctrl
  import addr_filter_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned LO_W      = 16
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               regWrEn,
  input  logic [ADDR_W-1:0]                  regAddr,
  input  logic [DATA_W-1:0]                  regWrData,
  input  logic                               rxValid,
  input  logic                               rxSof,
  input  logic                               rxEof,
  output fltCfg_t                            cfg,
  output logic [NUM_SLOTS-1:0][DATA_W+LO_W-1:0] slotAddr,
  output logic [NUM_SLOTS-1:0]               slotValid,
  output fltStrobe_t                         strobe
);

  localparam logic [ADDR_W-1:0] CFG_ADDR  = '0;
  localparam int unsigned       SLOT_BASE = 2;

  logic inFrame;

  // Configuration register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (regWrEn && regAddr == CFG_ADDR) begin
      cfg <= fltCfg_t'(regWrData[CFG_W-1:0]);
    end
  end

  // Address slots
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : gSlot
    localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(SLOT_BASE + 2*k);
    localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(SLOT_BASE + 2*k + 1);
    logic [DATA_W+LO_W-1:0] addrQ;
    logic                   validQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrQ  <= '0;
        validQ <= 1'b0;
      end else if (regWrEn && regAddr == HI_ADDR) begin
        addrQ[DATA_W+LO_W-1:LO_W] <= regWrData;
        validQ <= 1'b0;
      end else if (regWrEn && regAddr == LO_ADDR) begin
        addrQ[LO_W-1:0] <= regWrData[LO_W-1:0];
        validQ <= 1'b1;
      end
    end

    assign slotAddr[k]  = addrQ;
    assign slotValid[k] = validQ;

    // R2
    hi_write_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
      (regWrEn && regAddr == HI_ADDR) |=> !slotValid[k]);
    // R2
    lo_write_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
      (regWrEn && regAddr == LO_ADDR) |=>
        (slotValid[k] && slotAddr[k][LO_W-1:0] == $past(regWrData[LO_W-1:0])));
  end

  // Frame tracking
  always_comb begin
    strobe.frameStart = rxValid && rxSof;
    strobe.byteEn     = rxValid && (rxSof || inFrame);
    strobe.frameEnd   = rxValid && rxEof && (rxSof || inFrame);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame <= 1'b0;
    end else if (strobe.frameEnd) begin
      inFrame <= 1'b0;
    end else if (strobe.frameStart) begin
      inFrame <= 1'b1;
    end
  end

  // R10
  end_needs_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inFrame && !rxSof) |-> !strobe.frameEnd);

endmodule

// File: rtl/addr_filter_dp.sv
module addr_filter_dp
  import addr_filter_pkg::*;
#(
  parameter int unsigned NUM_SLOTS    = 4,
  parameter int unsigned ADDR_BYTES   = 6,
  parameter int unsigned CODE_W       = 32,
  parameter int unsigned BCAST_BIT    = 31,
  parameter int unsigned SLOT_TOP_BIT = 26,
  parameter int unsigned MIN_LEN      = 6,
  parameter int unsigned STD_LEN      = 1518,
  parameter int unsigned JUMBO_LEN    = 1536,
  parameter int unsigned MAX_LEN      = 10240
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  fltStrobe_t                           strobe,
  input  logic [7:0]                           rxData,
  input  fltCfg_t                              cfg,
  input  logic [NUM_SLOTS-1:0][ADDR_BYTES*8-1:0] slotAddr,
  input  logic [NUM_SLOTS-1:0]                 slotValid,
  output logic                                 decValid,
  output logic                                 decAccept,
  output logic [CODE_W-1:0]                    decCode
);

  localparam int unsigned DA_W  = ADDR_BYTES * 8;
  localparam int unsigned LEN_W = $clog2(MAX_LEN + 2);
  localparam logic [LEN_W-1:0] MIN_L   = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] STD_L   = LEN_W'(STD_LEN);
  localparam logic [LEN_W-1:0] JUMBO_L = LEN_W'(JUMBO_LEN);
  localparam logic [LEN_W-1:0] MAX_L   = LEN_W'(MAX_LEN);

  logic [DA_W-1:0]      destQ, destNext;
  logic [LEN_W-1:0]     lenQ, lenNext;
  logic [NUM_SLOTS-1:0] slotHit;
  logic                 bcastHit, lenOk, found;
  logic [CODE_W-1:0]    matchCode;

  // Length counter saturates one above the maximum
  always_comb begin
    if (strobe.frameStart)   lenNext = LEN_W'(1);
    else if (lenQ > MAX_L)   lenNext = lenQ;
    else                     lenNext = lenQ + LEN_W'(1);
  end

  // Insert the current byte into the address image
  always_comb begin
    destNext = strobe.frameStart ? '0 : destQ;
    for (int b = 0; b < ADDR_BYTES; b++) begin
      if (strobe.frameStart ? (b == 0) : (lenQ == LEN_W'(b)))
        destNext[DA_W-1-8*b -: 8] = rxData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      destQ <= '0;
      lenQ  <= '0;
    end else if (strobe.byteEn) begin
      destQ <= destNext;
      lenQ  <= lenNext;
    end
  end

  // Parallel slot comparators
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : gCmp
    assign slotHit[k] = slotValid[k] && (slotAddr[k] == destNext);
  end
  assign bcastHit = !cfg.noBcast && (&destNext);

  // Fixed-priority code selection
  always_comb begin
    matchCode = '0;
    found     = 1'b0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (!found && slotHit[k]) begin
        matchCode[SLOT_TOP_BIT-k] = 1'b1;
        found = 1'b1;
      end
    end
    if (!found && bcastHit) matchCode[BCAST_BIT] = 1'b1;
  end

  always_comb begin
    lenOk = (lenNext >= MIN_L) && (lenNext <= MAX_L)
         && ((lenNext <= JUMBO_L) || cfg.jumboEn)
         && ((lenNext <= STD_L) || cfg.bigEn);
  end

  // Registered verdict
  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid  <= 1'b0;
      decAccept <= 1'b0;
      decCode   <= '0;
    end else begin
      decValid  <= strobe.frameEnd;
      decCode   <= (strobe.frameEnd && lenOk) ? matchCode : '0;
      decAccept <= strobe.frameEnd && lenOk && ((matchCode != '0) || cfg.copyAll);
    end
  end

  // R9
  strobe_after_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frameEnd |=> decValid);
  // R9
  strobe_only_after_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.frameEnd |=> !decValid);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |-> (!decAccept && decCode == '0));
  // R4
  code_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(decCode));
  // R6
  code_implies_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decCode != '0) |-> decAccept);
  // R6
  unmatched_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && decAccept && decCode == '0) |-> $past(cfg.copyAll));
  // R7
  kept_len_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && decAccept) |-> ($past(lenNext) >= MIN_L && $past(lenNext) <= MAX_L));

endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import addr_filter_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CODE_W    = 32,
  parameter int unsigned MAX_LEN   = 10240
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              rxSof,
  input  logic              rxEof,
  output logic              decValid,
  output logic              decAccept,
  output logic [CODE_W-1:0] decCode
);

  localparam int unsigned LO_W = 16;
  localparam int unsigned DA_W = DATA_W + LO_W;

  fltStrobe_t                   strobe;
  fltCfg_t                      cfg;
  logic [NUM_SLOTS-1:0][DA_W-1:0] slotAddr;
  logic [NUM_SLOTS-1:0]         slotValid;

  addr_filter_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LO_W(LO_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .rxValid(rxValid), .rxSof(rxSof), .rxEof(rxEof),
    .cfg(cfg), .slotAddr(slotAddr), .slotValid(slotValid), .strobe(strobe)
  );

  addr_filter_dp #(
    .NUM_SLOTS(NUM_SLOTS), .ADDR_BYTES(DA_W/8), .CODE_W(CODE_W), .MAX_LEN(MAX_LEN)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxData(rxData), .cfg(cfg),
    .slotAddr(slotAddr), .slotValid(slotValid),
    .decValid(decValid), .decAccept(decAccept), .decCode(decCode)
  );

endmodule

// File: tb/dest_addr_filter_tb.sv
module dest_addr_filter_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxSof = 1'b0;
  logic        rxEof = 1'b0;
  logic        decValid, decAccept;
  logic [31:0] decCode;

  int checks = 0;
  int errors = 0;

  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

  always #(CLK_PERIOD/2) clk = ~clk;

  dest_addr_filter dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .rxValid(rxValid), .rxData(rxData),
    .rxSof(rxSof), .rxEof(rxEof), .decValid(decValid),
    .decAccept(decAccept), .decCode(decCode)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'(a); regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic setSlot(int k, logic [47:0] a);
    wr(2 + 2*k, a[47:16]);
    wr(3 + 2*k, {16'hBEEF, a[15:0]});
  endtask

  function automatic logic [31:0] slotCode(int k);
    return 32'h1 << (26 - k);
  endfunction

  // Sends a frame, then checks strobe, verdict and strobe drop
  task automatic expectFrame(string req, logic [47:0] da, int len,
                             logic expAcc, logic [31:0] expCode);
    logic v1, acc, v2;
    logic [31:0] code;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rxValid = 1'b1; rxSof = (i == 0); rxEof = (i == len - 1);
      rxData = (i < 6) ? da[47-8*i -: 8] : 8'(i * 7 + 3);
    end
    @(negedge clk);
    rxValid = 1'b0; rxSof = 1'b0; rxEof = 1'b0;
    v1 = decValid; acc = decAccept; code = decCode;
    @(negedge clk);
    v2 = decValid;
    check(req, {29'd0, v1, acc, v2, code}, {29'd0, 1'b1, expAcc, 1'b0, expCode});
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] addrA;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 idle strobe", {63'd0, decValid}, 64'd0);
    expectFrame("R1 zero dest", 48'h0, 64, 1'b0, 32'h0);
    expectFrame("R1 bcast", BCAST, 64, 1'b1, 32'h8000_0000);

    // R3 distinct slots, byte order; upper write bits ignored (R2)
    for (int k = 0; k < 4; k++) setSlot(k, 48'h0A1B_2C3D_4E50 + 48'(k));
    for (int k = 0; k < 4; k++)
      expectFrame("R3 slot match", 48'h0A1B_2C3D_4E50 + 48'(k), 64, 1'b1, slotCode(k));
    expectFrame("R3 reversed bytes", 48'h504E_3D2C_1B0A, 64, 1'b0, 32'h0);

    // R2 upper write invalidates, lower write revalidates
    wr(2, 32'h0A1B_2C3D);
    expectFrame("R2 invalidated", 48'h0A1B_2C3D_4E50, 64, 1'b0, 32'h0);
    wr(3, 32'h1234_4E50);
    expectFrame("R2 revalidated", 48'h0A1B_2C3D_4E50, 64, 1'b1, slotCode(0));

    // R4 priority over all valid-flag patterns
    addrA = 48'h0211_2233_4455;
    for (int m = 0; m < 16; m++) begin
      logic [31:0] exp;
      exp = 32'h0;
      for (int k = 0; k < 4; k++) begin
        wr(2 + 2*k, addrA[47:16]);
        if (m[k]) wr(3 + 2*k, {16'h0, addrA[15:0]});
      end
      for (int k = 3; k >= 0; k--) if (m[k]) exp = slotCode(k);
      expectFrame("R4 priority", addrA, 64, exp != 0, exp);
    end

    // R5 / R6 broadcast and keep-all combinations
    for (int c = 0; c < 4; c++) begin
      logic nbc, keep;
      nbc = c[0]; keep = c[1];
      wr(0, 32'(c));
      expectFrame("R5 bcast cfg", BCAST, 64, !nbc || keep, nbc ? 32'h0 : 32'h8000_0000);
      expectFrame("R6 unmatched cfg", 48'h0600_0000_0001, 64, keep, 32'h0);
    end

    // R7 / R8 length limits under every oversize setting
    for (int c = 0; c < 4; c++) begin
      int lens[8] = '{5, 6, 1518, 1519, 1536, 1537, 10240, 10241};
      logic jum, big;
      jum = c[0]; big = c[1];
      wr(0, {28'd0, big, jum, 2'b00});
      foreach (lens[i]) begin
        int L;
        logic ok;
        L  = lens[i];
        ok = (L >= 6) && (L <= 10240) && (L <= 1536 || jum) && (L <= 1518 || big);
        expectFrame((L < 6 || L > 10240) ? "R7 length" : "R8 oversize",
                    BCAST, L, ok, ok ? 32'h8000_0000 : 32'h0);
      end
    end

    // R10 stray end marker outside a frame
    wr(0, 32'h0);
    @(negedge clk);
    rxValid = 1'b1; rxEof = 1'b1; rxData = 8'hFF;
    @(negedge clk);
    rxValid = 1'b0; rxEof = 1'b0;
    check("R10 stray end", {63'd0, decValid}, 64'd0);
    @(negedge clk);
    check("R10 stray end later", {63'd0, decValid}, 64'd0);

    // R10 restart: partial frame then new start; length restarts
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      rxValid = 1'b1; rxSof = (i == 0); rxEof = 1'b0; rxData = 8'h11;
    end
    expectFrame("R10 restart", BCAST, 1518, 1'b1, 32'h8000_0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule